// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the byte-wide register face of an SMBus host controller. A simple register bus (write strobe, read strobe, 4-bit offset, 8-bit data) reaches three registers: a host status register with sticky event flags, a host control register that both configures and launches a transaction, and an auxiliary control register with two mode enables. On the other side it drives a transaction engine with a one-cycle start pulse, the selected protocol code, a PEC enable and a one-cycle abort pulse. In return it takes completion, byte-done, error and alert indications from the engine.

Software claims the host by reading the status register, which sets an in-use flag. It then launches a transaction with one control write and either waits for the interrupt output or polls the busy bit. Event flags stay set until software writes a 1 to their position. A kill write during a transaction aborts it and leaves the failed flag set. The active-low reset is applied asynchronously and released through a synchronizer.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register reads 0, and irq, eng_start, eng_abort, aux_crc_en and aux_blk_en are 0.
- R2: A control write (offset 2) with bit6 set, bit1 clear and the host idle produces eng_start high for exactly the next cycle. The same write sets busy (status bit0) and captures bits 4:2 as eng_proto and bit7 as eng_pec_en. Bit6 always reads back as 0.
- R3: While busy, a control write starts nothing and changes only the kill bit (control bit1). Protocol and PEC enable keep their values.
- R4: A control write with bit1 set while busy clears busy, sets failed (status bit4) and pulses eng_abort for one cycle, all at the next edge. A write with both bit6 and bit1 set while idle starts nothing.
- R5: While busy, eng_done sets interrupt (bit1), eng_dev_err sets device error (bit2) and eng_bus_err sets bus error (bit3); each of these ends busy. eng_byte_done sets byte done (bit7) and busy stays set. All four inputs are ignored while idle.
- R6: A status write (offset 0) clears each of bits 7, 4, 3, 2 and 1 where the written bit is 1. Writing bit0 or bit5 has no effect.
- R7: A status read returns the current value and then sets in-use (bit6). Writing 1 to bit6 clears it.
- R8: Status bit5 reflects the eng_alert input level.
- R9: irq is high exactly while any of status bits 1, 2, 3 or 4 is set.
- R10: Auxiliary control (offset 13) holds bits 1:0, which drive aux_blk_en (bit1) and aux_crc_en (bit0). Its other bits read 0, and every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| eng_done | input | 1 | Engine: transaction completed |
| eng_byte_done | input | 1 | Engine: one byte transferred |
| eng_dev_err | input | 1 | Engine: no acknowledge |
| eng_bus_err | input | 1 | Engine: arbitration lost |
| eng_alert | input | 1 | Alert line level |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_proto | output | 3 | Selected protocol code |
| eng_pec_en | output | 1 | PEC enabled for this transaction |
| eng_abort | output | 1 | One-cycle abort pulse |
| aux_crc_en | output | 1 | Hardware CRC enable |
| aux_blk_en | output | 1 | Block buffer mode enable |
| irq | output | 1 | Interrupt request |

## Verification
Register and flag updates take effect at the edge that ends the write or event cycle. The bench therefore samples the following read one full cycle later. eng_start and eng_abort are registered, so each is high in the cycle right after the causing write and low one cycle after that; the bench samples both at the two falling edges that follow. irq and bus_rdata are combinational from the registers, so they are sampled mid-cycle. Each read checks its data before the edge that sets in-use, which lets a second read observe the flag.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int PW = 3;

  // register offsets
  localparam logic [AW-1:0] OFS_STS  = 4'd0;
  localparam logic [AW-1:0] OFS_CTL  = 4'd2;
  localparam logic [AW-1:0] OFS_AUXC = 4'd13;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_INTR  = 1;
  localparam int ST_DEV   = 2;
  localparam int ST_BUS   = 3;
  localparam int ST_FAIL  = 4;
  localparam int ST_ALERT = 5;
  localparam int ST_INUSE = 6;
  localparam int ST_BYTE  = 7;

  localparam logic [DW-1:0] STICKY_MASK = 8'h9E;
  localparam logic [DW-1:0] IRQ_MASK    = 8'h1E;

  // control bit positions
  localparam int CT_KILL  = 1;
  localparam int CT_PLO   = 2;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;

  // auxiliary control bit positions
  localparam int AX_CRC = 0;
  localparam int AX_BLK = 1;
  localparam int AXW    = 2;
endpackage

// File: rtl/smb_status_reg.sv
module smb_status_reg
  import smb_regs_pkg::*;
#(
  parameter logic [DW-1:0] STICKY = STICKY_MASK,
  parameter logic [DW-1:0] IRQ_M  = IRQ_MASK
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  input  logic          inuse_set,
  input  logic          busy_set,
  input  logic          busy_clr,
  input  logic          alert_in,
  output logic [DW-1:0] sts,
  output logic          busy,
  output logic          irq
);
  logic [DW-1:0] flag_q;
  logic          busy_q, busy_d;
  logic          inuse_q, inuse_d;
  logic          inuse_en, busy_en;

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_bit
      if (STICKY[i]) begin : g_sticky
        logic d, en;
        always_comb begin
          en = set_vec[i] | clr_vec[i];
          d  = set_vec[i] | (flag_q[i] & ~clr_vec[i]);
        end
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni)  flag_q[i] <= 1'b0;
          else if (en)  flag_q[i] <= d;
        end
      end else begin : g_plain
        assign flag_q[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    inuse_en = inuse_set | clr_vec[ST_INUSE];
    inuse_d  = inuse_set & ~clr_vec[ST_INUSE];
    busy_en  = busy_set | busy_clr;
    busy_d   = busy_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      inuse_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (inuse_en) inuse_q <= inuse_d;
      if (busy_en)  busy_q  <= busy_d;
    end
  end

  always_comb begin
    sts           = flag_q;
    sts[ST_BUSY]  = busy_q;
    sts[ST_ALERT] = alert_in;
    sts[ST_INUSE] = inuse_q;
  end

  assign busy = busy_q;
  assign irq  = |(flag_q & IRQ_M);

  logic unused_bits;
  assign unused_bits = ^{set_vec & ~STICKY, clr_vec & ~STICKY & ~(8'h1 << ST_INUSE)};
endmodule

// File: rtl/smb_ctrl_reg.sv
module smb_ctrl_reg
  import smb_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic          start_req,
  output logic          abort_req,
  output logic          start_pulse,
  output logic          abort_pulse,
  output logic [PW-1:0] proto,
  output logic          pec_en,
  output logic [DW-1:0] ctl
);
  logic          kill_q, kill_d;
  logic          pec_q, pec_d;
  logic [PW-1:0] proto_q, proto_d;
  logic          cfg_en;
  logic          start_q, abort_q;

  always_comb begin
    start_req = wr_ctl & wdata[CT_START] & ~wdata[CT_KILL] & ~busy;
    abort_req = wr_ctl & wdata[CT_KILL] & busy;
    cfg_en    = wr_ctl & ~busy;
    kill_d    = wdata[CT_KILL];
    pec_d     = wdata[CT_PEC];
    proto_d   = wdata[CT_PLO +: PW];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      kill_q  <= 1'b0;
      pec_q   <= 1'b0;
      proto_q <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (wr_ctl) kill_q <= kill_d;
      if (cfg_en) begin
        pec_q   <= pec_d;
        proto_q <= proto_d;
      end
      start_q <= start_req;
      abort_q <= abort_req;
    end
  end

  always_comb begin
    ctl               = '0;
    ctl[CT_KILL]      = kill_q;
    ctl[CT_PEC]       = pec_q;
    ctl[CT_PLO +: PW] = proto_q;
  end

  assign start_pulse = start_q;
  assign abort_pulse = abort_q;
  assign proto       = proto_q;
  assign pec_en      = pec_q;

  logic unused_bits;
  assign unused_bits = ^{wdata[0], wdata[5]};
endmodule

// File: rtl/smb_aux_reg.sv
module smb_aux_reg
  import smb_regs_pkg::*;
(
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           wr_aux,
  input  logic [AXW-1:0] wbits,
  output logic [DW-1:0]  aux
);
  logic [AXW-1:0] aux_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     aux_q <= '0;
    else if (wr_aux) aux_q <= wbits;
  end

  always_comb begin
    aux            = '0;
    aux[AXW-1:0]   = aux_q;
  end
endmodule

// File: rtl/smb_rd_mux.sv
module smb_rd_mux
  import smb_regs_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] sts,
  input  logic [DW-1:0] ctl,
  input  logic [DW-1:0] aux,
  output logic [DW-1:0] rdata
);
  always_comb begin
    unique case (addr)
      OFS_STS:  rdata = sts;
      OFS_CTL:  rdata = ctl;
      OFS_AUXC: rdata = aux;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          eng_done,
  input  logic          eng_byte_done,
  input  logic          eng_dev_err,
  input  logic          eng_bus_err,
  input  logic          eng_alert,
  output logic          eng_start,
  output logic [PW-1:0] eng_proto,
  output logic          eng_pec_en,
  output logic          eng_abort,
  output logic          aux_crc_en,
  output logic          aux_blk_en,
  output logic          irq
);
  // reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_STAGES-1];

  logic          wr_sts, wr_ctl, wr_aux, rd_sts;
  logic          busy, start_req, abort_req;
  logic [DW-1:0] sts, ctl, aux;
  logic [DW-1:0] set_vec, clr_vec;
  logic          ev_done, ev_dev, ev_bus, ev_byte, busy_clr;

  always_comb begin
    wr_sts = bus_wr & (bus_addr == OFS_STS);
    wr_ctl = bus_wr & (bus_addr == OFS_CTL);
    wr_aux = bus_wr & (bus_addr == OFS_AUXC);
    rd_sts = bus_rd & ~bus_wr & (bus_addr == OFS_STS);

    ev_done = eng_done      & busy;
    ev_dev  = eng_dev_err   & busy;
    ev_bus  = eng_bus_err   & busy;
    ev_byte = eng_byte_done & busy;

    set_vec          = '0;
    set_vec[ST_INTR] = ev_done;
    set_vec[ST_DEV]  = ev_dev;
    set_vec[ST_BUS]  = ev_bus;
    set_vec[ST_FAIL] = abort_req;
    set_vec[ST_BYTE] = ev_byte;

    clr_vec  = wr_sts ? bus_wdata : '0;
    busy_clr = ev_done | ev_dev | ev_bus | abort_req;
  end

  smb_status_reg u_sts (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .inuse_set (rd_sts),
    .busy_set  (start_req),
    .busy_clr  (busy_clr),
    .alert_in  (eng_alert),
    .sts       (sts),
    .busy      (busy),
    .irq       (irq)
  );

  smb_ctrl_reg u_ctl (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .wr_ctl      (wr_ctl),
    .wdata       (bus_wdata),
    .busy        (busy),
    .start_req   (start_req),
    .abort_req   (abort_req),
    .start_pulse (eng_start),
    .abort_pulse (eng_abort),
    .proto       (eng_proto),
    .pec_en      (eng_pec_en),
    .ctl         (ctl)
  );

  smb_aux_reg u_aux (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr_aux (wr_aux),
    .wbits  (bus_wdata[AXW-1:0]),
    .aux    (aux)
  );

  smb_rd_mux u_mux (
    .addr  (bus_addr),
    .sts   (sts),
    .ctl   (ctl),
    .aux   (aux),
    .rdata (bus_rdata)
  );

  assign aux_crc_en = aux[AX_CRC];
  assign aux_blk_en = aux[AX_BLK];
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
  import smb_regs_pkg::*;
(
  input logic          clk,
  input logic          rst_ni,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] sts,
  input logic          eng_start,
  input logic          eng_abort,
  input logic          eng_done,
  input logic          irq
);
  logic ctl_w, sts_w;
  assign ctl_w = bus_wr && (bus_addr == OFS_CTL);
  assign sts_w = bus_wr && (bus_addr == OFS_STS);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_start |=> !eng_start);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_start |-> sts[ST_BUSY]);

  assert_no_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_w && sts[ST_BUSY]) |=> !eng_start);

  assert_kill_abort_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_w && bus_wdata[CT_KILL] && sts[ST_BUSY]) |=> (!sts[ST_BUSY] && sts[ST_FAIL] && eng_abort));

  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (eng_done && sts[ST_BUSY] && !bus_wr) |=> (!sts[ST_BUSY] && sts[ST_INTR]));

  assert_w1c_fail_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (sts_w && bus_wdata[ST_FAIL]) |=> !sts[ST_FAIL]);

  assert_inuse_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && !bus_wr && bus_addr == OFS_STS) |=> sts[ST_INUSE]);

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> $past(sts[ST_BUSY]));
endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sts       (sts),
  .eng_start (eng_start),
  .eng_abort (eng_abort),
  .eng_done  (eng_done),
  .irq       (irq)
);

// File: tb/tb_smb_host_regs.sv
module tb_smb_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       eng_done = 1'b0, eng_byte_done = 1'b0, eng_dev_err = 1'b0;
  logic       eng_bus_err = 1'b0, eng_alert = 1'b0;
  logic       eng_start, eng_pec_en, eng_abort, aux_crc_en, aux_blk_en, irq;
  logic [2:0] eng_proto;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  smb_host_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .eng_byte_done(eng_byte_done),
    .eng_dev_err(eng_dev_err), .eng_bus_err(eng_bus_err),
    .eng_alert(eng_alert), .eng_start(eng_start), .eng_proto(eng_proto),
    .eng_pec_en(eng_pec_en), .eng_abort(eng_abort),
    .aux_crc_en(aux_crc_en), .aux_blk_en(aux_blk_en), .irq(irq)
  );

  // op codes: 0 write, 1 read+check, 2 done, 3 dev err, 4 bus err, 5 byte done
  // entry: {op[3:0], addr[3:0], wdata[7:0], expected[7:0], req[7:0]}
  localparam int NV = 38;
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 4'd2,  8'h00, 8'h00, 8'd1},   // R1 control reset
    {4'd1, 4'd13, 8'h00, 8'h00, 8'd1},   // R1 aux reset
    {4'd1, 4'd0,  8'h00, 8'h00, 8'd1},   // R1 status reset
    {4'd1, 4'd0,  8'h00, 8'h40, 8'd7},   // R7 in-use after read
    {4'd0, 4'd0,  8'h40, 8'h00, 8'd7},   // R7 clear in-use
    {4'd0, 4'd13, 8'h03, 8'h00, 8'd10},  // R10
    {4'd1, 4'd13, 8'h00, 8'h03, 8'd10},  // R10
    {4'd0, 4'd13, 8'hFE, 8'h00, 8'd10},  // R10 upper bits dropped
    {4'd1, 4'd13, 8'h00, 8'h02, 8'd10},  // R10
    {4'd1, 4'd3,  8'h00, 8'h00, 8'd10},  // R10 other offset
    {4'd0, 4'd2,  8'hC8, 8'h00, 8'd2},   // R2 start proto 2 pec
    {4'd1, 4'd2,  8'h00, 8'h88, 8'd2},   // R2 start reads 0
    {4'd1, 4'd0,  8'h00, 8'h01, 8'd2},   // R2 busy
    {4'd0, 4'd2,  8'hDC, 8'h00, 8'd3},   // R3 write while busy
    {4'd1, 4'd2,  8'h00, 8'h88, 8'd3},   // R3 config held
    {4'd5, 4'd0,  8'h00, 8'h00, 8'd5},   // R5 byte done
    {4'd1, 4'd0,  8'h00, 8'hC1, 8'd5},   // R5 still busy
    {4'd2, 4'd0,  8'h00, 8'h00, 8'd5},   // R5 done
    {4'd1, 4'd0,  8'h00, 8'hC2, 8'd5},   // R5 intr, idle
    {4'd0, 4'd0,  8'h03, 8'h00, 8'd6},   // R6 clear intr, bit0 ignored
    {4'd1, 4'd0,  8'h00, 8'hC0, 8'd6},   // R6
    {4'd0, 4'd0,  8'h80, 8'h00, 8'd6},   // R6 clear byte done
    {4'd1, 4'd0,  8'h00, 8'h40, 8'd6},   // R6
    {4'd0, 4'd2,  8'h44, 8'h00, 8'd2},   // R2 start proto 1
    {4'd3, 4'd0,  8'h00, 8'h00, 8'd5},   // R5 dev err
    {4'd1, 4'd0,  8'h00, 8'h44, 8'd5},   // R5
    {4'd4, 4'd0,  8'h00, 8'h00, 8'd5},   // R5 bus err while idle
    {4'd2, 4'd0,  8'h00, 8'h00, 8'd5},   // R5 done while idle
    {4'd1, 4'd0,  8'h00, 8'h44, 8'd5},   // R5 idle events ignored
    {4'd0, 4'd2,  8'h50, 8'h00, 8'd2},   // R2 start proto 4
    {4'd4, 4'd0,  8'h00, 8'h00, 8'd5},   // R5 bus err
    {4'd1, 4'd0,  8'h00, 8'h4C, 8'd5},   // R5
    {4'd0, 4'd0,  8'h0C, 8'h00, 8'd6},   // R6 clear both errors
    {4'd1, 4'd0,  8'h00, 8'h40, 8'd6},   // R6
    {4'd0, 4'd2,  8'h42, 8'h00, 8'd4},   // R4 start+kill idle
    {4'd1, 4'd2,  8'h00, 8'h02, 8'd4},   // R4
    {4'd1, 4'd0,  8'h00, 8'h40, 8'd4},   // R4 not busy
    {4'd0, 4'd2,  8'h00, 8'h00, 8'd4}    // R4 clear kill
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_ev(input int op);
    @(negedge clk);
    case (op)
      2: eng_done = 1'b1;
      3: eng_dev_err = 1'b1;
      4: eng_bus_err = 1'b1;
      default: eng_byte_done = 1'b1;
    endcase
    @(posedge clk); #1;
    eng_done = 1'b0; eng_dev_err = 1'b0; eng_bus_err = 1'b0; eng_byte_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: outputs after reset
    @(negedge clk);
    check("R1", {3'b0, irq, eng_start, eng_abort, aux_crc_en, aux_blk_en}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, a;
      logic [7:0] wd, ex, rq;
      {op, a, wd, ex, rq} = VEC[i];
      case (op)
        4'd0: do_write(a, wd);
        4'd1: begin
          do_read(a, rd);
          check($sformatf("R%0d vec%0d", rq, i), rd, ex);
        end
        default: pulse_ev(int'(op));
      endcase
    end

    // R2: start pulse width and captured fields (proto 3, pec)
    do_write(4'd2, 8'hCC);
    @(negedge clk);
    check("R2 start high", {eng_start, eng_pec_en, 3'b0, eng_proto}, 8'hC3);
    @(negedge clk);
    check("R2 start one cycle", {7'b0, eng_start}, 8'h00);

    // R6: writing busy bit has no effect
    do_write(4'd0, 8'h01);
    do_read(4'd0, rd);
    check("R6 busy write ignored", rd, 8'h41);
    check("R9 irq low", {7'b0, irq}, 8'h00);

    // R4: kill while busy
    do_write(4'd2, 8'h02);
    @(negedge clk);
    check("R4 abort pulse", {7'b0, eng_abort}, 8'h01);
    @(negedge clk);
    check("R4 abort one cycle", {7'b0, eng_abort}, 8'h00);
    do_read(4'd0, rd);
    check("R4 failed, not busy", rd, 8'h50);
    check("R9 irq on failed", {7'b0, irq}, 8'h01);
    do_read(4'd2, rd);
    check("R3 only kill changed", rd, 8'h8E);

    // R6/R9: clear failed drops irq
    do_write(4'd0, 8'h10);
    @(negedge clk);
    check("R9 irq cleared", {7'b0, irq}, 8'h00);
    do_read(4'd0, rd);
    check("R6 failed cleared", rd, 8'h40);
    do_write(4'd2, 8'h00);

    // R8: alert mirror
    eng_alert = 1'b1;
    do_read(4'd0, rd);
    check("R8 alert", rd, 8'h60);
    eng_alert = 1'b0;

    // R9: irq from completion
    do_write(4'd2, 8'h40);
    pulse_ev(2);
    @(negedge clk);
    check("R9 irq on intr", {7'b0, irq}, 8'h01);
    do_write(4'd0, 8'h02);
    @(negedge clk);
    check("R9 irq after clear", {7'b0, irq}, 8'h00);

    // R7: clear in-use, next read returns it clear
    do_write(4'd0, 8'h40);
    do_read(4'd0, rd);
    check("R7 in-use cleared", rd, 8'h00);

    // R10: aux outputs
    do_write(4'd13, 8'h01);
    @(negedge clk);
    check("R10 aux outputs", {6'b0, aux_blk_en, aux_crc_en}, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule